// File: doc/BRIEF.md
# In-Order Retirement Buffer with Precise Redirects

This block keeps a window of in-flight instructions in program order. The front end claims one slot per instruction at the tail and gives the slot's destination register. The slot index is returned as a tag. Execution units finish work in any order. Each one reports back by tag with a result value, and may also raise a fault (with a code) or a mispredicted-jump flag (with the correct target).

Slots leave strictly from the head, one per cycle. A slot leaves only once it has executed. When a normal slot retires, its value goes out on a register-file write port. Faults and mispredicts are only noted at completion time; nothing happens until that slot is the oldest.

- A faulting head is not committed. The whole window is discarded and a fault redirect is raised.
- A mispredicted jump commits its own result first. Everything younger is then discarded and a redirect to the correct target is raised.
- A pending interrupt is taken on the next retirement. That retirement commits, and everything younger is discarded.

Every discard also pulses a one-cycle flush line, which the rename table uses to reset itself.

Top module: `rob_precise`

## Requirements
- R1: Out of reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `rf_we`, `redirect_valid` and `flush_pulse` are 0.
- R2: Tags are handed out in order 0,1,…,15 and then wrap. With 16 slots occupied, `alloc_ready` is 0 and an allocation request is dropped.
- R3: Register-file writes occur in allocation order, at most one per cycle, carrying the slot's destination and its completed value, whatever the completion order. The write is visible in the cycle after the clock edge at which the head slot is complete.
- R4: While the head slot has not completed, nothing retires, even if younger slots have.
- R5: A faulting head causes no register write. It produces `redirect_kind`=1 (fault) together with its fault code, and empties the buffer.
- R6: A mispredicted-jump head writes its result and produces `redirect_kind`=2 with its target in the same cycle. All younger slots are discarded.
- R7: While `irq_pending` is 1, the next normal retirement writes its result and produces `redirect_kind`=3 in the same cycle. All younger slots are discarded. A mispredict at the head takes precedence.
- R8: Every redirect comes with a one-cycle `flush_pulse`. After it the buffer is empty and the next tag is 0. An allocation or completion presented in the flush cycle is dropped.
- R9: A completion whose tag names an unoccupied slot has no effect. A later allocation of that slot does not retire until its own completion arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to claim a slot |
| alloc_dest | input | 5 | Architectural destination of the new instruction |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | 4 | Tag the next allocation receives |
| cmpl_valid | input | 1 | Completion report |
| cmpl_tag | input | 4 | Slot being completed |
| cmpl_data | input | 32 | Result value |
| cmpl_fault | input | 1 | Instruction faulted |
| cmpl_fcode | input | 4 | Fault code |
| cmpl_mispred | input | 1 | Jump was mispredicted |
| cmpl_target | input | 32 | Correct-path address for a mispredicted jump |
| irq_pending | input | 1 | Interrupt waiting to be taken |
| rf_we | output | 1 | Architectural register write |
| rf_addr | output | 5 | Register written |
| rf_data | output | 32 | Value written |
| redirect_valid | output | 1 | Front end must be re-steered |
| redirect_kind | output | 2 | 1 fault, 2 mispredict, 3 interrupt |
| redirect_target | output | 32 | Correct path for a mispredict, else 0 |
| redirect_fcode | output | 4 | Fault code for a fault, else 0 |
| flush_pulse | output | 1 | One-cycle rename reset |

## Verification
`alloc_ready` and `alloc_tag` are combinational from the current occupancy. The bench checks them one time unit after driving inputs on the falling edge. Retirement writes, redirects and the flush pulse are registered at the rising edge where the head is seen complete. The bench steps its reference model once per cycle before that edge and compares those outputs on the following falling edge, so each result is expected exactly one edge after its cause. Completions and allocations in a flush cycle are discarded in the model as in R8.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef enum logic [1:0] {
      RD_NONE  = 2'd0,
      RD_FAULT = 2'd1,
      RD_MISP  = 2'd2,
      RD_IRQ   = 2'd3
   } redir_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_fire,
   input  logic             retire_fire,
   input  logic             flush,
   output logic [IDX_W-1:0] head_idx,
   output logic [IDX_W-1:0] tail_idx,
   output logic             full,
   output logic             empty
);
   logic [PTR_W-1:0] head_q, tail_q;
   logic [PTR_W-1:0] occ;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (retire_fire) head_q <= head_q + PTR_W'(1);
         if (alloc_fire)  tail_q <= tail_q + PTR_W'(1);
      end
   end

   assign occ      = tail_q - head_q;
   assign head_idx = head_q[IDX_W-1:0];
   assign tail_idx = tail_q[IDX_W-1:0];
   assign full     = (head_q[IDX_W] != tail_q[IDX_W]) && (head_idx == tail_idx);
   assign empty    = (head_q == tail_q);

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= PTR_W'(DEPTH));
   a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !alloc_fire);
   a_r8_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
   parameter int DEPTH   = 16,
   parameter int DATA_W  = 32,
   parameter int AREG_W  = 5,
   parameter int FCODE_W = 4,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               alloc_fire,
   input  logic [IDX_W-1:0]   alloc_idx,
   input  logic [AREG_W-1:0]  alloc_dest,
   input  logic               cmpl_valid,
   input  logic [IDX_W-1:0]   cmpl_idx,
   input  logic [DATA_W-1:0]  cmpl_data,
   input  logic               cmpl_fault,
   input  logic [FCODE_W-1:0] cmpl_fcode,
   input  logic               cmpl_mispred,
   input  logic [DATA_W-1:0]  cmpl_target,
   input  logic               retire_fire,
   input  logic [IDX_W-1:0]   head_idx,
   output logic               head_valid,
   output logic               head_done,
   output logic               head_fault,
   output logic               head_mis,
   output logic [AREG_W-1:0]  head_dest,
   output logic [DATA_W-1:0]  head_data,
   output logic [DATA_W-1:0]  head_target,
   output logic [FCODE_W-1:0] head_fcode
);
   logic [DEPTH-1:0]   valid_v, done_v, fault_v, mis_v;
   logic [AREG_W-1:0]  dest_a   [DEPTH];
   logic [DATA_W-1:0]  data_a   [DEPTH];
   logic [DATA_W-1:0]  target_a [DEPTH];
   logic [FCODE_W-1:0] fcode_a  [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         logic               v_q, d_q, f_q, m_q;
         logic [AREG_W-1:0]  dst_q;
         logic [DATA_W-1:0]  dat_q, tgt_q;
         logic [FCODE_W-1:0] fc_q;
         logic hit_alloc, hit_cmpl, hit_ret;

         assign hit_alloc = alloc_fire  && (alloc_idx == IDX_W'(e));
         assign hit_cmpl  = cmpl_valid  && (cmpl_idx  == IDX_W'(e)) && v_q;
         assign hit_ret   = retire_fire && (head_idx  == IDX_W'(e));

         always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
               v_q <= 1'b0;
               d_q <= 1'b0;
            end else if (hit_alloc) begin
               v_q <= 1'b1;
               d_q <= 1'b0;
            end else begin
               if (hit_ret)  v_q <= 1'b0;
               if (hit_cmpl) d_q <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               f_q   <= 1'b0;
               m_q   <= 1'b0;
               dst_q <= '0;
               dat_q <= '0;
               tgt_q <= '0;
               fc_q  <= '0;
            end else if (hit_alloc) begin
               f_q   <= 1'b0;
               m_q   <= 1'b0;
               dst_q <= alloc_dest;
            end else if (hit_cmpl) begin
               f_q   <= cmpl_fault;
               m_q   <= cmpl_mispred;
               dat_q <= cmpl_data;
               tgt_q <= cmpl_target;
               fc_q  <= cmpl_fcode;
            end
         end

         assign valid_v[e]  = v_q;
         assign done_v[e]   = d_q;
         assign fault_v[e]  = f_q;
         assign mis_v[e]    = m_q;
         assign dest_a[e]   = dst_q;
         assign data_a[e]   = dat_q;
         assign target_a[e] = tgt_q;
         assign fcode_a[e]  = fc_q;
      end
   endgenerate

   assign head_valid  = valid_v[head_idx];
   assign head_done   = done_v[head_idx];
   assign head_fault  = fault_v[head_idx];
   assign head_mis    = mis_v[head_idx];
   assign head_dest   = dest_a[head_idx];
   assign head_data   = data_a[head_idx];
   assign head_target = target_a[head_idx];
   assign head_fcode  = fcode_a[head_idx];

   // R4: an unfinished head stays put unless the window is discarded
   a_r4_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && !head_done && !flush && !cmpl_valid) |=> head_valid);
   a_r9_no_done_without_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_v == '0 && !alloc_fire) |=> (valid_v == '0));
endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl
   import rob_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int AREG_W  = 5,
   parameter int FCODE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               head_valid,
   input  logic               head_done,
   input  logic               head_fault,
   input  logic               head_mis,
   input  logic [AREG_W-1:0]  head_dest,
   input  logic [DATA_W-1:0]  head_data,
   input  logic [DATA_W-1:0]  head_target,
   input  logic [FCODE_W-1:0] head_fcode,
   input  logic               irq_pending,
   output logic               retire_fire,
   output logic               flush,
   output logic               rf_we,
   output logic [AREG_W-1:0]  rf_addr,
   output logic [DATA_W-1:0]  rf_data,
   output logic               redirect_valid,
   output redir_e             redirect_kind,
   output logic [DATA_W-1:0]  redirect_target,
   output logic [FCODE_W-1:0] redirect_fcode,
   output logic               flush_pulse
);
   redir_e kind;

   always_comb begin
      retire_fire = 1'b0;
      flush       = 1'b0;
      kind        = RD_NONE;
      if (head_valid && head_done) begin
         if (head_fault) begin
            flush = 1'b1;
            kind  = RD_FAULT;
         end else begin
            retire_fire = 1'b1;
            if (head_mis) begin
               flush = 1'b1;
               kind  = RD_MISP;
            end else if (irq_pending) begin
               flush = 1'b1;
               kind  = RD_IRQ;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rf_we           <= 1'b0;
         rf_addr         <= '0;
         rf_data         <= '0;
         redirect_valid  <= 1'b0;
         redirect_kind   <= RD_NONE;
         redirect_target <= '0;
         redirect_fcode  <= '0;
         flush_pulse     <= 1'b0;
      end else begin
         rf_we           <= retire_fire;
         rf_addr         <= head_dest;
         rf_data         <= head_data;
         redirect_valid  <= (kind != RD_NONE);
         redirect_kind   <= kind;
         redirect_target <= (kind == RD_MISP)  ? head_target : '0;
         redirect_fcode  <= (kind == RD_FAULT) ? head_fcode  : '0;
         flush_pulse     <= flush;
      end
   end

   a_r5_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_kind == RD_FAULT) |-> !rf_we);
   a_r6_misp_commits: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_kind == RD_MISP) |-> rf_we);
   a_r7_irq_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_kind == RD_IRQ) |-> rf_we);
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |=> !flush_pulse);
   a_r8_pulse_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse == redirect_valid);
endmodule

// File: rtl/rob_precise.sv
module rob_precise
   import rob_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int DATA_W  = 32,
   parameter int AREG_W  = 5,
   parameter int FCODE_W = 4,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alloc_valid,
   input  logic [AREG_W-1:0]  alloc_dest,
   output logic               alloc_ready,
   output logic [IDX_W-1:0]   alloc_tag,
   input  logic               cmpl_valid,
   input  logic [IDX_W-1:0]   cmpl_tag,
   input  logic [DATA_W-1:0]  cmpl_data,
   input  logic               cmpl_fault,
   input  logic [FCODE_W-1:0] cmpl_fcode,
   input  logic               cmpl_mispred,
   input  logic [DATA_W-1:0]  cmpl_target,
   input  logic               irq_pending,
   output logic               rf_we,
   output logic [AREG_W-1:0]  rf_addr,
   output logic [DATA_W-1:0]  rf_data,
   output logic               redirect_valid,
   output logic [1:0]         redirect_kind,
   output logic [DATA_W-1:0]  redirect_target,
   output logic [FCODE_W-1:0] redirect_fcode,
   output logic               flush_pulse
);
   logic               full, empty, flush, retire_fire, alloc_fire, cmpl_fire;
   logic [IDX_W-1:0]   head_idx, tail_idx;
   logic               h_valid, h_done, h_fault, h_mis;
   logic [AREG_W-1:0]  h_dest;
   logic [DATA_W-1:0]  h_data, h_target;
   logic [FCODE_W-1:0] h_fcode;
   redir_e             kind_q;

   generate
      if (DATA_W < 1 || AREG_W < 1 || FCODE_W < 1) begin : g_bad_width
         $error("widths must be positive");
      end
   endgenerate

   assign alloc_ready   = !full;
   assign alloc_tag     = tail_idx;
   assign alloc_fire    = alloc_valid && !full && !flush;
   assign cmpl_fire     = cmpl_valid && !flush;
   assign redirect_kind = kind_q;

   rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .retire_fire(retire_fire),
      .flush(flush), .head_idx(head_idx), .tail_idx(tail_idx), .full(full), .empty(empty)
   );

   rob_entry_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W), .FCODE_W(FCODE_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc_fire(alloc_fire), .alloc_idx(tail_idx), .alloc_dest(alloc_dest),
      .cmpl_valid(cmpl_fire), .cmpl_idx(cmpl_tag), .cmpl_data(cmpl_data),
      .cmpl_fault(cmpl_fault), .cmpl_fcode(cmpl_fcode), .cmpl_mispred(cmpl_mispred),
      .cmpl_target(cmpl_target), .retire_fire(retire_fire), .head_idx(head_idx),
      .head_valid(h_valid), .head_done(h_done), .head_fault(h_fault), .head_mis(h_mis),
      .head_dest(h_dest), .head_data(h_data), .head_target(h_target), .head_fcode(h_fcode)
   );

   rob_retire_ctrl #(.DATA_W(DATA_W), .AREG_W(AREG_W), .FCODE_W(FCODE_W)) u_ret (
      .clk(clk), .rst_n(rst_n), .head_valid(h_valid), .head_done(h_done),
      .head_fault(h_fault), .head_mis(h_mis), .head_dest(h_dest), .head_data(h_data),
      .head_target(h_target), .head_fcode(h_fcode), .irq_pending(irq_pending),
      .retire_fire(retire_fire), .flush(flush), .rf_we(rf_we), .rf_addr(rf_addr),
      .rf_data(rf_data), .redirect_valid(redirect_valid), .redirect_kind(kind_q),
      .redirect_target(redirect_target), .redirect_fcode(redirect_fcode),
      .flush_pulse(flush_pulse)
   );

   a_r8_ready_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |-> (alloc_ready && alloc_tag == '0));
   a_r4_empty_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      $past(empty) |-> !rf_we);
endmodule

// File: tb/rob_precise_tb.sv
`timescale 1ns/1ps
module rob_precise_tb;
   localparam int DEPTH = 16, DW = 32, AW = 5, FW = 4, IW = 4;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          alloc_valid = 0, alloc_ready;
   logic [AW-1:0] alloc_dest = '0, rf_addr;
   logic [IW-1:0] alloc_tag, cmpl_tag = '0;
   logic          cmpl_valid = 0, cmpl_fault = 0, cmpl_mispred = 0, irq_pending = 0;
   logic [DW-1:0] cmpl_data = '0, cmpl_target = '0, rf_data, redirect_target;
   logic [FW-1:0] cmpl_fcode = '0, redirect_fcode;
   logic          rf_we, redirect_valid, flush_pulse;
   logic [1:0]    redirect_kind;

   rob_precise u_dut (.*);

   always #2 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit fin = 0;

   bit            m_v[DEPTH], m_d[DEPTH], m_f[DEPTH], m_m[DEPTH];
   logic [AW-1:0] m_dst[DEPTH];
   logic [DW-1:0] m_dat[DEPTH], m_tgt[DEPTH];
   logic [FW-1:0] m_fc[DEPTH];
   int            m_head = 0, m_tail = 0, m_cnt = 0;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // drives are set by the caller at a falling edge; this runs one clock
   task automatic cycle();
      bit            e_we = 0, fl = 0;
      logic [AW-1:0] e_addr = '0;
      logic [DW-1:0] e_data = '0, e_tgt = '0;
      logic [FW-1:0] e_fc = '0;
      logic [1:0]    e_kind = 0;
      bit            rdy;
      int            h;
      string         kreq;
      #1;
      rdy = (m_cnt < DEPTH);
      chk("R2", "alloc_ready", alloc_ready, rdy);
      if (rdy) chk("R2", "alloc_tag", alloc_tag, m_tail);
      h = m_head;
      if (m_v[h] && m_d[h]) begin
         if (m_f[h]) begin
            e_kind = 1; e_fc = m_fc[h]; fl = 1;
         end else begin
            e_we = 1; e_addr = m_dst[h]; e_data = m_dat[h];
            m_v[h] = 0; m_head = (h + 1) % DEPTH; m_cnt--;
            if (m_m[h]) begin e_kind = 2; e_tgt = m_tgt[h]; fl = 1; end
            else if (irq_pending) begin e_kind = 3; fl = 1; end
         end
      end
      if (fl) begin
         for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
         m_head = 0; m_tail = 0; m_cnt = 0;
      end else begin
         if (cmpl_valid && m_v[cmpl_tag]) begin
            m_d[cmpl_tag] = 1; m_f[cmpl_tag] = cmpl_fault; m_m[cmpl_tag] = cmpl_mispred;
            m_dat[cmpl_tag] = cmpl_data; m_tgt[cmpl_tag] = cmpl_target; m_fc[cmpl_tag] = cmpl_fcode;
         end
         if (alloc_valid && rdy) begin
            m_v[m_tail] = 1; m_d[m_tail] = 0; m_f[m_tail] = 0; m_m[m_tail] = 0;
            m_dst[m_tail] = alloc_dest; m_tail = (m_tail + 1) % DEPTH; m_cnt++;
         end
      end
      @(posedge clk);
      @(negedge clk);
      chk("R3", "rf_we", rf_we, e_we);
      if (e_we) begin
         chk("R3", "rf_addr", rf_addr, e_addr);
         chk("R3", "rf_data", rf_data, e_data);
      end
      kreq = (e_kind == 1) ? "R5" : (e_kind == 2) ? "R6" : "R7";
      chk(kreq, "redirect_kind", redirect_kind, e_kind);
      chk(kreq, "redirect_valid", redirect_valid, e_kind != 0);
      if (e_kind == 2) chk("R6", "redirect_target", redirect_target, e_tgt);
      if (e_kind == 1) chk("R5", "redirect_fcode", redirect_fcode, e_fc);
      chk("R8", "flush_pulse", flush_pulse, fl);
   endtask

   task automatic idle();
      alloc_valid = 0; cmpl_valid = 0; cmpl_fault = 0; cmpl_mispred = 0; irq_pending = 0;
   endtask

   task automatic do_alloc(logic [AW-1:0] d);
      idle(); alloc_valid = 1; alloc_dest = d; cycle(); idle();
   endtask

   task automatic do_cmpl(int t, logic [DW-1:0] v, bit f, bit m, logic [FW-1:0] fc);
      idle(); cmpl_valid = 1; cmpl_tag = IW'(t); cmpl_data = v; cmpl_fault = f;
      cmpl_mispred = m; cmpl_fcode = fc; cmpl_target = v ^ 32'hA5A5_0000;
      cycle(); idle();
   endtask

   task automatic finish_run();
      fin = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         n_bad++;
         $display("FAIL R1 watchdog act=running exp=finished");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h0BAD_5EED));
      for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "alloc_ready", alloc_ready, 1);
      chk("R1", "alloc_tag", alloc_tag, 0);
      chk("R1", "rf_we", rf_we, 0);
      chk("R1", "redirect_valid", redirect_valid, 0);
      chk("R1", "flush_pulse", flush_pulse, 0);

      // R2: fill the window, the seventeenth request is dropped
      for (int i = 0; i < DEPTH + 1; i++) do_alloc(AW'(i + 3));
      chk("R2", "alloc_ready when full", alloc_ready, 0);
      // R4: younger slots complete, head stays pending
      for (int i = DEPTH - 1; i >= 1; i--) do_cmpl(i, 32'h100 + i, 0, 0, 0);
      chk("R4", "rf_we while head pending", rf_we, 0);
      do_cmpl(0, 32'h100, 0, 0, 0);
      for (int i = 0; i < DEPTH + 1; i++) begin idle(); cycle(); end

      // R9: completion to an empty slot, then the slot is reused
      do_cmpl(m_tail, 32'hDEAD, 0, 0, 0);
      do_alloc(5'd9);
      repeat (3) begin idle(); cycle(); end
      chk("R9", "stale completion ignored", rf_we, 0);
      do_cmpl((m_tail + DEPTH - 1) % DEPTH, 32'h77, 0, 0, 0);
      idle(); cycle();

      // R5 fault behind an ordinary slot
      for (int i = 0; i < 3; i++) do_alloc(AW'(20 + i));
      do_cmpl((m_tail + DEPTH - 2) % DEPTH, 32'h1, 1, 0, 4'hC);
      do_cmpl((m_tail + DEPTH - 1) % DEPTH, 32'h2, 0, 0, 0);
      do_cmpl((m_tail + DEPTH - 3) % DEPTH, 32'h3, 0, 0, 0);
      repeat (3) begin idle(); cycle(); end
      chk("R8", "tag after flush", alloc_tag, 0);

      // R6 mispredict commits then discards the younger slot
      do_alloc(5'd1); do_alloc(5'd2);
      do_cmpl(1, 32'h55, 0, 0, 0);
      do_cmpl(0, 32'h44, 0, 1, 0);
      repeat (2) begin idle(); cycle(); end

      // R7 interrupt on next retirement; R8 allocation during flush cycle dropped
      do_alloc(5'd3); do_alloc(5'd4);
      do_cmpl(0, 32'h66, 0, 0, 0);
      idle(); irq_pending = 1; alloc_valid = 1; alloc_dest = 5'd7; cycle(); idle();
      chk("R7", "tag after interrupt", alloc_tag, 0);
      repeat (2) begin idle(); cycle(); end

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         int t;
         idle();
         alloc_valid = ($urandom % 10) < 6;
         alloc_dest  = AW'($urandom);
         t = $urandom % DEPTH;
         if (m_v[t] && !m_d[t]) begin
            cmpl_valid = 1;
         end else if ($urandom % 8 == 0) begin
            cmpl_valid = 1;
         end
         cmpl_tag     = IW'(t);
         cmpl_data    = $urandom;
         cmpl_target  = $urandom;
         cmpl_fcode   = FW'($urandom);
         cmpl_fault   = ($urandom % 40) == 0;
         cmpl_mispred = ($urandom % 20) == 0;
         irq_pending  = ($urandom % 50) == 0;
         cycle();
      end
      idle();
      finish_run();
   end
endmodule